// File: doc/BRIEF.md
# Bus-Mapped ALU Coprocessor

This block is an 8-bit arithmetic/logic unit that sits on a processor bus as a peripheral. The processor writes operand A and operand B with separate device-select codes. It then writes an operation command on the upper data lines. The command picks one of sixteen functions, chooses arithmetic or logic mode, and supplies a carry-in bit. The unit runs the operation in the cycle after the command arrives. It latches the 8-bit result and drives the carry-out onto a flag line that the processor samples as a status input.

The processor reads the result with a read cycle carrying a fourth select code. The block answers one cycle later with a registered data word and an output-enable. An external pad drives the shared bus only while that enable is high. Write cycles are ignored unless the read/write line is high, so a read never disturbs the stored operands.

Top module: `alu_copro`

## Requirements
- R1: After synchronous reset, rd_oe, rd_data and carry_flag are all 0, and a result read before any command returns 0x00.
- R2: A strobed cycle with bus_rw=1 and bus_sel=1 loads operand A from bus_wdata[7:0]. The same cycle with bus_sel=2 loads operand B from bus_wdata[7:0].
- R3: A strobed cycle with bus_rw=1 and bus_sel=3 loads a command, and bits 3:0 of that command word are ignored. The fields are: bus_wdata[9] is the mode (1 = logic, 0 = arithmetic), bus_wdata[8:5] is the function select S, and bus_wdata[4] is the carry-in.
- R4: A strobed cycle with bus_rw=0 never changes operand A, operand B or the command, whatever the select code.
- R5: A strobed cycle with bus_rw=0 and bus_sel=4 makes rd_oe 1 and rd_data equal the stored result after the next clock edge. In every other cycle rd_oe is 0 and rd_data is 0x00.
- R6: In arithmetic mode the result and carry are the 9-bit sum P+Q+cin, with result = bits 7:0 and carry = bit 8. P and Q depend on S as follows: P = A | (S[0] ? B : 0) | (S[1] ? ~B : 0), and Q = (S[2] ? A&~B : 0) | (S[3] ? A&B : 0). For example, S=9 gives A+B, S=6 gives A-B-1 and S=3 gives all ones.
- R7: In logic mode the result is ~P ^ Q with P and Q as in R6. This gives, for S=0 to 15 in turn: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A. The carry-in is ignored in logic mode.
- R8: Two clock edges after a command write, carry_flag equals the carry of R6 in arithmetic mode, and it is 0 in logic mode.
- R9: A command write clears carry_flag at the next edge. Outside command writes and their execution, carry_flag keeps its value.
- R10: The stored result changes only when a command executes. Operand writes after a command do not alter the value that a later read returns.
- R11: Strobed writes or reads with select codes 0 or 5 to 15 have no effect on any stored value and do not raise rd_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Bus cycle strobe |
| bus_rw | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_sel | input | 4 | Device-select code |
| bus_wdata | input | 10 | Write data lines |
| rd_data | output | 8 | Registered read-back data, 0 when not enabled |
| rd_oe | output | 1 | Output enable for the external bus driver |
| carry_flag | output | 1 | Carry-out flag to the processor |

## Verification
The case hardest to reach from the ports is the flag's two-step update. A command write first clears the flag. The carry of the new operation then appears one edge later. A stale 1 left over from the previous operation is therefore visible only in the single cycle between those two edges. The bench runs every function, mode and carry-in over operand pairs that mix carrying and non-carrying cases, so the flag often goes from 1 to 0 and back to 1. It samples the flag in both cycles after each command. A read-cycle write, an out-of-range select and an operand write after a command are each followed by a command or a read that exposes the stored value.

// File: rtl/alu_copro_pkg.sv
package alu_copro_pkg;
  // Command word as it sits on the upper bus lines, MSB first
  typedef struct packed {
    logic       logic_mode;
    logic [3:0] fsel;
    logic       cin;
  } alu_cmd_t;

  localparam int CMD_W = $bits(alu_cmd_t);
endpackage

// File: rtl/alu_copro_decode.sv
module alu_copro_decode #(
  parameter int SEL_W   = 4,
  parameter int SEL_OPA = 1,
  parameter int SEL_OPB = 2,
  parameter int SEL_CMD = 3,
  parameter int SEL_RES = 4
) (
  input  logic             stb,
  input  logic             rw,
  input  logic [SEL_W-1:0] sel,
  output logic             wr_a,
  output logic             wr_b,
  output logic             wr_cmd,
  output logic             rd_res
);
  logic wr_cyc;
  logic rd_cyc;

  always_comb begin
    wr_cyc = stb & rw;
    rd_cyc = stb & ~rw;
    wr_a   = wr_cyc && (sel == SEL_W'(SEL_OPA));
    wr_b   = wr_cyc && (sel == SEL_W'(SEL_OPB));
    wr_cmd = wr_cyc && (sel == SEL_W'(SEL_CMD));
    rd_res = rd_cyc && (sel == SEL_W'(SEL_RES));
  end
endmodule

// File: rtl/alu_copro_regs.sv
module alu_copro_regs
  import alu_copro_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              wr_cmd,
  input  logic [BUS_W-1:0]  wdata,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output alu_cmd_t          cmd,
  output logic              exec
);
  localparam int CMD_LSB = BUS_W - CMD_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      opa  <= '0;
      opb  <= '0;
      cmd  <= '0;
      exec <= 1'b0;
    end else begin
      if (wr_a) opa <= wdata[DATA_W-1:0];
      if (wr_b) opb <= wdata[DATA_W-1:0];
      if (wr_cmd) cmd <= alu_cmd_t'(wdata[BUS_W-1:CMD_LSB]);
      exec <= wr_cmd;
    end
  end
endmodule

// File: rtl/alu_copro_core.sv
module alu_copro_core
  import alu_copro_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_cmd_t          cmd,
  output logic [DATA_W-1:0] f,
  output logic              cout
);
  logic [DATA_W-1:0] p_term;
  logic [DATA_W-1:0] q_term;
  logic [DATA_W:0]   sum;

  // Per-bit operand shaping shared by both modes
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign p_term[i] = a[i] | (cmd.fsel[0] & b[i]) | (cmd.fsel[1] & ~b[i]);
    assign q_term[i] = (cmd.fsel[2] & a[i] & ~b[i]) | (cmd.fsel[3] & a[i] & b[i]);
  end

  always_comb begin
    sum = {1'b0, p_term} + {1'b0, q_term} + {{DATA_W{1'b0}}, cmd.cin};
    if (cmd.logic_mode) begin
      f    = ~p_term ^ q_term;
      cout = 1'b0;
    end else begin
      f    = sum[DATA_W-1:0];
      cout = sum[DATA_W];
    end
  end
endmodule

// File: rtl/alu_copro_readback.sv
module alu_copro_readback #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  logic              wr_cmd,
  input  logic              rd_res,
  input  logic [DATA_W-1:0] f,
  input  logic              cout,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              carry_flag
);
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q   <= '0;
      carry_flag <= 1'b0;
      rd_data    <= '0;
      rd_oe      <= 1'b0;
    end else begin
      if (exec) result_q <= f;
      if (wr_cmd)    carry_flag <= 1'b0;
      else if (exec) carry_flag <= cout;
      rd_oe   <= rd_res;
      rd_data <= rd_res ? result_q : '0;
    end
  end
endmodule

// File: rtl/alu_copro.sv
module alu_copro
  import alu_copro_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BUS_W   = 10,
  parameter int SEL_W   = 4,
  parameter int SEL_OPA = 1,
  parameter int SEL_OPB = 2,
  parameter int SEL_CMD = 3,
  parameter int SEL_RES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_stb,
  input  logic              bus_rw,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              carry_flag
);
  logic              wr_a, wr_b, wr_cmd, rd_res;
  logic [DATA_W-1:0] opa, opb, alu_f;
  logic              alu_cout;
  logic              exec_q;
  alu_cmd_t          cmd_q;

  alu_copro_decode #(
    .SEL_W(SEL_W), .SEL_OPA(SEL_OPA), .SEL_OPB(SEL_OPB),
    .SEL_CMD(SEL_CMD), .SEL_RES(SEL_RES)
  ) u_dec (
    .stb(bus_stb), .rw(bus_rw), .sel(bus_sel),
    .wr_a(wr_a), .wr_b(wr_b), .wr_cmd(wr_cmd), .rd_res(rd_res)
  );

  alu_copro_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b), .wr_cmd(wr_cmd),
    .wdata(bus_wdata), .opa(opa), .opb(opb), .cmd(cmd_q), .exec(exec_q)
  );

  alu_copro_core #(.DATA_W(DATA_W)) u_core (
    .a(opa), .b(opb), .cmd(cmd_q), .f(alu_f), .cout(alu_cout)
  );

  alu_copro_readback #(.DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .exec(exec_q), .wr_cmd(wr_cmd), .rd_res(rd_res),
    .f(alu_f), .cout(alu_cout), .rd_data(rd_data), .rd_oe(rd_oe),
    .carry_flag(carry_flag)
  );
endmodule

// File: rtl/alu_copro_chk.sv
module alu_copro_chk
  import alu_copro_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 4,
  parameter int SEL_CMD = 3,
  parameter int SEL_RES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_stb,
  input logic              bus_rw,
  input logic [SEL_W-1:0]  bus_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_oe,
  input logic              carry_flag,
  input alu_cmd_t          cmd_q,
  input logic              exec_q
);
  logic rd_req, cmd_req;
  assign rd_req  = bus_stb && !bus_rw && (bus_sel == SEL_W'(SEL_RES));
  assign cmd_req = bus_stb && bus_rw && (bus_sel == SEL_W'(SEL_CMD));

  p_oe_follows_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_oe);
  p_oe_only_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> $past(rd_req));
  p_idle_data_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_oe |-> (rd_data == '0));
  p_cmd_clears_flag_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_req |=> !carry_flag);
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(carry_flag) |-> ($past(cmd_req) || $past(exec_q)));
  p_logic_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (exec_q && cmd_q.logic_mode) |=> !carry_flag);
  p_flag_rise_arith_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_flag) |-> ($past(exec_q) && !$past(cmd_q.logic_mode)));
endmodule

bind alu_copro alu_copro_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_CMD(SEL_CMD), .SEL_RES(SEL_RES)
) u_chk (
  .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_rw(bus_rw), .bus_sel(bus_sel),
  .rd_data(rd_data), .rd_oe(rd_oe), .carry_flag(carry_flag),
  .cmd_q(cmd_q), .exec_q(exec_q)
);

// File: tb/alu_copro_test.sv
module alu_copro_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_stb = 1'b0;
  logic       bus_rw = 1'b0;
  logic [3:0] bus_sel = 4'd0;
  logic [9:0] bus_wdata = 10'd0;
  logic [7:0] rd_data;
  logic       rd_oe;
  logic       carry_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu_copro uut (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_rw(bus_rw),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_oe(rd_oe), .carry_flag(carry_flag)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic rw, input logic [3:0] sel, input logic [9:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_rw = rw; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0; bus_rw = 1'b0; bus_sel = 4'd0; bus_wdata = 10'd0;
  endtask

  // Read result; returns at negedge after the registering edge
  task automatic read_res(output logic [7:0] d, output logic oe);
    bus_cycle(1'b0, 4'd4, 10'd0);
    d = rd_data; oe = rd_oe;
  endtask

  function automatic logic [9:0] cmd_word(input logic m, input logic [3:0] s, input logic c);
    return {m, s, c, 4'hF};
  endfunction

  function automatic logic [8:0] z(input logic [7:0] x);
    return {1'b0, x};
  endfunction

  // Independent model: {carry, result}
  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [3:0] s, input logic m, input logic c);
    logic [8:0] ci;
    logic [8:0] r;
    ci = {8'd0, c};
    if (m) begin
      case (s)
        4'd0:  r = z(~a);
        4'd1:  r = z(~(a | b));
        4'd2:  r = z(~a & b);
        4'd3:  r = z(8'h00);
        4'd4:  r = z(~(a & b));
        4'd5:  r = z(~b);
        4'd6:  r = z(a ^ b);
        4'd7:  r = z(a & ~b);
        4'd8:  r = z(~a | b);
        4'd9:  r = z(~(a ^ b));
        4'd10: r = z(b);
        4'd11: r = z(a & b);
        4'd12: r = z(8'hFF);
        4'd13: r = z(a | ~b);
        4'd14: r = z(a | b);
        default: r = z(a);
      endcase
    end else begin
      case (s)
        4'd0:  r = z(a) + ci;
        4'd1:  r = z(a | b) + ci;
        4'd2:  r = z(a | ~b) + ci;
        4'd3:  r = z(8'hFF) + ci;
        4'd4:  r = z(a) + z(a & ~b) + ci;
        4'd5:  r = z(a | b) + z(a & ~b) + ci;
        4'd6:  r = z(a) + z(~b) + ci;
        4'd7:  r = z(a & ~b) + z(8'hFF) + ci;
        4'd8:  r = z(a) + z(a & b) + ci;
        4'd9:  r = z(a) + z(b) + ci;
        4'd10: r = z(a | ~b) + z(a & b) + ci;
        4'd11: r = z(a & b) + z(8'hFF) + ci;
        4'd12: r = z(a) + z(a) + ci;
        4'd13: r = z(a | b) + z(a) + ci;
        4'd14: r = z(a | ~b) + z(a) + ci;
        default: r = z(a) + z(8'hFF) + ci;
      endcase
    end
    return r;
  endfunction

  // Issue a command and check flag clear, flag update and result
  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [3:0] s,
                        input logic m, input logic c);
    logic [8:0] exp;
    logic [7:0] d;
    logic oe;
    exp = model(a, b, s, m, c);
    bus_cycle(1'b1, 4'd3, cmd_word(m, s, c));
    chk("R9 flag cleared by command", {8'd0, carry_flag}, 9'd0);
    @(negedge clk);
    chk(m ? "R8 R7 logic flag" : "R8 R6 arith flag", {8'd0, carry_flag}, {8'd0, exp[8]});
    read_res(d, oe);
    chk("R5 oe on read", {8'd0, oe}, 9'd1);
    chk(m ? "R7 logic result" : "R6 arith result", {1'b0, d}, {1'b0, exp[7:0]});
  endtask

  logic [7:0] pa [6] = '{8'h00, 8'hFF, 8'h5A, 8'h80, 8'h37, 8'hFF};
  logic [7:0] pb [6] = '{8'h00, 8'h01, 8'hA5, 8'h80, 8'hC9, 8'hFF};

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 rd_oe", {8'd0, rd_oe}, 9'd0);
    chk("R1 rd_data", {1'b0, rd_data}, 9'd0);
    chk("R1 carry_flag", {8'd0, carry_flag}, 9'd0);
    read_res(d, oe);
    chk("R1 result before command", {1'b0, d}, 9'd0);
    @(negedge clk);
    chk("R5 oe drops after read", {8'd0, rd_oe}, 9'd0);
    chk("R5 data zero when idle", {1'b0, rd_data}, 9'd0);

    // R2 R3 R6 R7 R8: sweep of all functions, modes and carry-ins
    for (int p = 0; p < 6; p++) begin
      bus_cycle(1'b1, 4'd1, {2'b11, pa[p]});
      bus_cycle(1'b1, 4'd2, {2'b11, pb[p]});
      for (int s = 0; s < 16; s++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 2; c++)
            run_op(pa[p], pb[p], 4'(s), 1'(m), 1'(c));
    end

    // R8: carry set, then a logic op clears it
    bus_cycle(1'b1, 4'd1, 10'h0FF);
    bus_cycle(1'b1, 4'd2, 10'h001);
    run_op(8'hFF, 8'h01, 4'd9, 1'b0, 1'b0);
    chk("R8 carry from FF+01", {8'd0, carry_flag}, 9'd1);
    run_op(8'hFF, 8'h01, 4'd9, 1'b1, 1'b1);
    chk("R8 logic mode flag low", {8'd0, carry_flag}, 9'd0);

    // R9: flag holds across operand writes and reads
    run_op(8'hFF, 8'h01, 4'd9, 1'b0, 1'b1);
    bus_cycle(1'b1, 4'd1, 10'h012);
    read_res(d, oe);
    repeat (3) @(negedge clk);
    chk("R9 flag held", {8'd0, carry_flag}, 9'd1);

    // R10: operand write after command leaves stored result
    bus_cycle(1'b1, 4'd1, 10'h011);
    bus_cycle(1'b1, 4'd2, 10'h022);
    run_op(8'h11, 8'h22, 4'd9, 1'b0, 1'b0);
    bus_cycle(1'b1, 4'd1, 10'h0F0);
    read_res(d, oe);
    chk("R10 result stable after operand write", {1'b0, d}, 9'h033);
    run_op(8'hF0, 8'h22, 4'd9, 1'b0, 1'b0);

    // R4: read cycles with write selects do not load
    bus_cycle(1'b0, 4'd1, 10'h0AA);
    bus_cycle(1'b0, 4'd2, 10'h0BB);
    bus_cycle(1'b0, 4'd3, cmd_word(1'b1, 4'd0, 1'b0));
    chk("R4 no oe for read on select 3", {8'd0, rd_oe}, 9'd0);
    read_res(d, oe);
    chk("R4 read cycle did not run command", {1'b0, d}, 9'h012);
    run_op(8'hF0, 8'h22, 4'd15, 1'b1, 1'b0);
    run_op(8'hF0, 8'h22, 4'd10, 1'b1, 1'b0);

    // R11: unused select codes
    for (int sc = 5; sc < 16; sc++) begin
      bus_cycle(1'b1, 4'(sc), 10'h3C3);
      bus_cycle(1'b0, 4'(sc), 10'h000);
      chk("R11 no oe for unused select", {8'd0, rd_oe}, 9'd0);
    end
    bus_cycle(1'b1, 4'd0, 10'h3C3);
    read_res(d, oe);
    chk("R11 result unchanged", {1'b0, d}, 9'h022);
    run_op(8'hF0, 8'h22, 4'd9, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule